// File: doc/BRIEF.md
# Programmable Asynchronous External Memory Strobe Sequencer

This block drives the control strobes of SRAM-like and NOR-type devices that sit on an asynchronous parallel bus. A host issues a single request with a direction, a chip-select index, an address and write data. The block then runs one access whose edges are all placed by a tick counter in functional clock cycles. The edges are chip select, address valid, output enable and write enable. It returns a one-cycle completion pulse, and on reads it also returns the sampled data.

Each chip select has its own configuration word. Its fields set the assert tick of each strobe and separate read and write release ticks. They also set the cycle length for each direction, the data-sample tick, the spacing to the next access, and per-strobe half-cycle shifts. Further fields give a doubling option for every time value, the device width, the multiplexing mode and the stall (wait) monitoring setup. A configuration word is loaded through a simple write port. Every field resets to zero.

Top module: `ext_mem_seq`

## Requirements
- R1: After reset every strobe output (`mem_cs_n`, `mem_adv_n`, `mem_oe_n`, `mem_we_n`) is high. `rsp_done` and `mem_dq_oe` are low, and `req_ready` is high.
- R2: Tick t of an access is shown on the pins from the rising edge t+1 after the accepting edge. Chip select of the requested line only is low for ticks cs_on through off-1. Here off is cs_rd_off for reads and cs_wr_off for writes. All other chip-select lines stay high.
- R3: Address valid is low for ticks adv_on through adv_rd_off-1 (reads) or adv_wr_off-1 (writes). In address-address-data mode (mux code 2) the alternate trio aad_adv_on, aad_adv_rd_off and aad_adv_wr_off is used instead. Codes 0 (none) and 1 (address-data) use the normal trio.
- R4: Output enable is low on reads only, for ticks oe_on through oe_off-1, or aad_oe_on through aad_oe_off-1 in mux code 2. Write enable is low on writes only, for ticks we_on through we_off-1.
- R5: An access lasts rd_cyc ticks (reads) or wr_cyc ticks (writes), with a value of 0 acting as 1. `rsp_done` is high for one cycle together with the last tick. On reads, `rsp_rdata` holds `mem_din` as sampled at the edge that ends tick acc.
- R6: After an access on line P ends, the next request is accepted no earlier than ta + g cycles after the first idle cycle. Here ta is P's turnaround value. g is P's c2c value when the new line equals P and P's same-line enable is set, or when the lines differ and P's other-line enable is set. Otherwise g is 0.
- R7: When a strobe's half-shift bit is set, both of its edges move half a clock period later.
- R8: When the doubling bit is set, every time value of that line counts twice as many ticks.
- R9: For a line configured 8 bits wide (dev16 = 0), bits 15:8 of `mem_dout` and `rsp_rdata` are zero.
- R10: When monitoring is enabled for the access direction, a high level on the selected wait pin stops the tick counter while the tick lies in [acc-wmon, acc]. All strobes hold during the stop. Wait is ignored at other ticks, on other pins, on pin indices at or above NUM_WAIT, and when monitoring is disabled for that direction.
- R11: With an all-zero configuration, a request completes with `rsp_done` one cycle after acceptance and asserts no strobe.
- R12: `mem_dq_oe` is high for exactly the ticks of a write access. `mem_addr` and `mem_dout` present the request address and write data from the accepting edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | functional clock |
| rst | input | 1 | synchronous active-high reset |
| cfg_wr | input | 1 | load configuration word |
| cfg_cs | input | CSW | line whose configuration is loaded |
| cfg_data | input | CFG_W | packed configuration word (seq_cfg_t) |
| req_valid | input | 1 | request present |
| req_ready | output | 1 | request accepted at next rising edge when valid |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_cs | input | CSW | target chip-select line |
| req_addr | input | ADDR_W | access address |
| req_wdata | input | DATA_W | write data |
| rsp_done | output | 1 | one-cycle completion pulse |
| rsp_rdata | output | DATA_W | sampled read data |
| mem_cs_n | output | NUM_CS | chip selects, active low |
| mem_adv_n | output | 1 | address valid, active low |
| mem_oe_n | output | 1 | output enable, active low |
| mem_we_n | output | 1 | write enable, active low |
| mem_addr | output | ADDR_W | device address |
| mem_dout | output | DATA_W | device write data |
| mem_dq_oe | output | 1 | drive enable for the data bus |
| mem_din | input | DATA_W | device read data |
| mem_wait | input | NUM_WAIT | device stall inputs, high = stall |

## Verification
The data-sample tick and the wait stall can coincide: the counter freezes on exactly the tick at which read data would be captured. The bench holds the selected wait pin high across the sample tick for three edges while `mem_din` changes every cycle. It expects the data present at the releasing edge, a completion three cycles late, and a chip select stretched by the same amount. A second coincidence is the end of one access with the next request already waiting. The bench counts the cycles `req_ready` stays low for a same-line and an other-line follow-up.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int TW  = 5;   // bits per time field
  localparam int WPW = 2;   // bits of wait pin index

  typedef enum logic [1:0] {
    MUX_NONE = 2'd0,
    MUX_AD   = 2'd1,
    MUX_AAD  = 2'd2
  } mux_e;

  typedef struct packed {
    logic           gran;
    logic [1:0]     mux;
    logic           dev16;
    logic           half_cs;
    logic           half_adv;
    logic           half_oe;
    logic           half_we;
    logic           c2c_same;
    logic           c2c_diff;
    logic           wait_rd;
    logic           wait_wr;
    logic [WPW-1:0] wait_pin;
    logic [TW-1:0]  cs_on;
    logic [TW-1:0]  cs_rd_off;
    logic [TW-1:0]  cs_wr_off;
    logic [TW-1:0]  adv_on;
    logic [TW-1:0]  adv_rd_off;
    logic [TW-1:0]  adv_wr_off;
    logic [TW-1:0]  aad_adv_on;
    logic [TW-1:0]  aad_adv_rd_off;
    logic [TW-1:0]  aad_adv_wr_off;
    logic [TW-1:0]  oe_on;
    logic [TW-1:0]  oe_off;
    logic [TW-1:0]  aad_oe_on;
    logic [TW-1:0]  aad_oe_off;
    logic [TW-1:0]  we_on;
    logic [TW-1:0]  we_off;
    logic [TW-1:0]  rd_cyc;
    logic [TW-1:0]  wr_cyc;
    logic [TW-1:0]  acc;
    logic [TW-1:0]  ta;
    logic [TW-1:0]  c2c;
    logic [TW-1:0]  wmon;
  } seq_cfg_t;
endpackage

// File: rtl/seq_cfg_bank.sv
module seq_cfg_bank
  import seq_pkg::*;
#(
  parameter int NUM_CS = 4,
  localparam int CSW = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CSW-1:0]    wr_sel,
  input  seq_cfg_t          wr_cfg,
  input  logic [CSW-1:0]    a_sel,
  output seq_cfg_t          a_cfg,
  input  logic [CSW-1:0]    b_sel,
  output seq_cfg_t          b_cfg,
  output logic [NUM_CS-1:0] half_cs_all
);
  seq_cfg_t bank [NUM_CS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_CS; i++) bank[i] <= '0;
    end else if (wr_en && (int'(wr_sel) < NUM_CS)) begin
      bank[wr_sel] <= wr_cfg;
    end
  end

  always_comb begin
    a_cfg = (int'(a_sel) < NUM_CS) ? bank[a_sel] : '0;
    b_cfg = (int'(b_sel) < NUM_CS) ? bank[b_sel] : '0;
  end

  for (genvar g = 0; g < NUM_CS; g++) begin : g_half
    assign half_cs_all[g] = bank[g].half_cs;
  end
endmodule

// File: rtl/seq_strobe.sv
module seq_strobe (
  input  logic clk,
  input  logic rst,
  input  logic act_i,
  input  logic half_i,
  output logic strobe_o
);
  logic rise_q;
  logic fall_q;

  always_ff @(posedge clk) begin
    if (rst) rise_q <= 1'b0;
    else     rise_q <= act_i;
  end

  always_ff @(negedge clk) begin
    if (rst) fall_q <= 1'b0;
    else     fall_q <= rise_q;
  end

  assign strobe_o = half_i ? fall_q : rise_q;
endmodule

// File: rtl/ext_mem_seq.sv
module ext_mem_seq
  import seq_pkg::*;
#(
  parameter int NUM_CS   = 4,
  parameter int NUM_WAIT = 2,
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 16,
  localparam int CSW   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
  localparam int CFG_W = $bits(seq_cfg_t)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [CSW-1:0]    cfg_cs,
  input  logic [CFG_W-1:0]  cfg_data,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_wr,
  input  logic [CSW-1:0]    req_cs,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [NUM_CS-1:0] mem_cs_n,
  output logic              mem_adv_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dout,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_din,
  input  logic [NUM_WAIT-1:0] mem_wait
);
  localparam int CW   = TW + 3;
  localparam int WPAD = 2 ** WPW;

  typedef enum logic {ST_IDLE, ST_ACT} st_e;

  function automatic logic [CW-1:0] scale(input logic [TW-1:0] t, input logic g);
    return g ? CW'({t, 1'b0}) : CW'(t);
  endfunction

  function automatic logic [DATA_W-1:0] narrow(input logic [DATA_W-1:0] d, input logic w16);
    logic [DATA_W-1:0] m;
    m = d;
    if (!w16) m[DATA_W-1:8] = '0;
    return m;
  endfunction

  st_e             st;
  logic [CW-1:0]   cnt;
  logic [CSW-1:0]  cur_cs, prev_cs;
  logic            cur_wr;
  logic [CW-1:0]   gap_ta, gap_c2c;
  logic            gap_same, gap_diff;
  logic [CW:0]     idle_cnt, need;
  seq_cfg_t        ca, cb;
  logic [NUM_CS-1:0] half_cs_all;

  seq_cfg_bank #(.NUM_CS(NUM_CS)) u_bank (
    .clk(clk), .rst(rst), .wr_en(cfg_wr), .wr_sel(cfg_cs),
    .wr_cfg(seq_cfg_t'(cfg_data)),
    .a_sel(cur_cs), .a_cfg(ca), .b_sel(req_cs), .b_cfg(cb),
    .half_cs_all(half_cs_all)
  );

  // request gating by spacing
  always_comb begin
    need = {1'b0, gap_ta};
    if ((req_cs == prev_cs) ? gap_same : gap_diff) need = need + {1'b0, gap_c2c};
  end
  assign req_ready = (st == ST_IDLE) && (idle_cnt >= need);

  // timing decode for the running access
  logic            aad, in_act, frozen, last, wait_en, wait_lvl;
  logic [CW-1:0]   cs_on, cs_off, adv_on, adv_off, oe_on, oe_off, we_on, we_off;
  logic [CW-1:0]   cyc, acc, wmon, win_lo;
  logic [WPAD-1:0] wpad;

  always_comb begin
    aad     = (ca.mux == MUX_AAD);
    in_act  = (st == ST_ACT);
    cs_on   = scale(ca.cs_on, ca.gran);
    cs_off  = scale(cur_wr ? ca.cs_wr_off : ca.cs_rd_off, ca.gran);
    adv_on  = scale(aad ? ca.aad_adv_on : ca.adv_on, ca.gran);
    adv_off = scale(aad ? (cur_wr ? ca.aad_adv_wr_off : ca.aad_adv_rd_off)
                        : (cur_wr ? ca.adv_wr_off : ca.adv_rd_off), ca.gran);
    oe_on   = scale(aad ? ca.aad_oe_on : ca.oe_on, ca.gran);
    oe_off  = scale(aad ? ca.aad_oe_off : ca.oe_off, ca.gran);
    we_on   = scale(ca.we_on, ca.gran);
    we_off  = scale(ca.we_off, ca.gran);
    cyc     = scale(cur_wr ? ca.wr_cyc : ca.rd_cyc, ca.gran);
    acc     = scale(ca.acc, ca.gran);
    wmon    = scale(ca.wmon, ca.gran);
    win_lo  = (acc > wmon) ? acc - wmon : '0;
    wpad    = '0;
    wpad[NUM_WAIT-1:0] = mem_wait;
    wait_en  = cur_wr ? ca.wait_wr : ca.wait_rd;
    wait_lvl = wpad[ca.wait_pin];
    frozen  = in_act && wait_en && wait_lvl && (cnt >= win_lo) && (cnt <= acc);
    last    = !frozen && ((cnt + 1'b1) >= cyc);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      cur_cs    <= '0;
      cur_wr    <= 1'b0;
      prev_cs   <= '0;
      gap_ta    <= '0;
      gap_c2c   <= '0;
      gap_same  <= 1'b0;
      gap_diff  <= 1'b0;
      idle_cnt  <= '0;
      rsp_done  <= 1'b0;
      rsp_rdata <= '0;
      mem_addr  <= '0;
      mem_dout  <= '0;
      mem_dq_oe <= 1'b0;
    end else begin
      rsp_done  <= 1'b0;
      mem_dq_oe <= in_act && cur_wr;
      if (st == ST_IDLE) begin
        if (idle_cnt != '1) idle_cnt <= idle_cnt + 1'b1;
        if (req_valid && req_ready) begin
          st       <= ST_ACT;
          cnt      <= '0;
          cur_cs   <= req_cs;
          cur_wr   <= req_wr;
          mem_addr <= req_addr;
          mem_dout <= narrow(req_wdata, cb.dev16);
        end
      end else if (!frozen) begin
        if (!cur_wr && (cnt == acc)) rsp_rdata <= narrow(mem_din, ca.dev16);
        if (last) begin
          st       <= ST_IDLE;
          rsp_done <= 1'b1;
          idle_cnt <= '0;
          prev_cs  <= cur_cs;
          gap_ta   <= scale(ca.ta, ca.gran);
          gap_c2c  <= scale(ca.c2c, ca.gran);
          gap_same <= ca.c2c_same;
          gap_diff <= ca.c2c_diff;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // strobe generation: one per chip-select line, then ADV, OE, WE
  logic [NUM_CS-1:0] cs_act, cs_strb;
  logic cs_win;
  assign cs_win = in_act && (cnt >= cs_on) && (cnt < cs_off);

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign cs_act[g] = cs_win && (int'(cur_cs) == g);
    seq_strobe u_cs (.clk(clk), .rst(rst), .act_i(cs_act[g]),
                     .half_i(half_cs_all[g]), .strobe_o(cs_strb[g]));
  end
  assign mem_cs_n = ~cs_strb;

  logic [2:0] c_act, c_half, c_strb;
  assign c_act[0]  = in_act && (cnt >= adv_on) && (cnt < adv_off);
  assign c_act[1]  = in_act && !cur_wr && (cnt >= oe_on) && (cnt < oe_off);
  assign c_act[2]  = in_act && cur_wr && (cnt >= we_on) && (cnt < we_off);
  assign c_half    = {ca.half_we, ca.half_oe, ca.half_adv};

  for (genvar g = 0; g < 3; g++) begin : g_ctl
    seq_strobe u_ctl (.clk(clk), .rst(rst), .act_i(c_act[g]),
                      .half_i(c_half[g]), .strobe_o(c_strb[g]));
  end
  assign mem_adv_n = ~c_strb[0];
  assign mem_oe_n  = ~c_strb[1];
  assign mem_we_n  = ~c_strb[2];

  // R2: at most one chip-select line low at any rising edge
  a_r2_cs_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~mem_cs_n));

  // R5: completion is a single-cycle pulse
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);

  // R10: a stall keeps the tick counter and the access in place
  a_r10_stall_hold: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ACT && frozen) |=> (st == ST_ACT && cnt == $past(cnt)));

  // R12: bus drive only while a write is in flight
  a_r12_dq_oe_write: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> cur_wr);

  // R4: write enable never low during a read access tick
  a_r4_no_we_on_read: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ACT && !cur_wr && $past(st == ST_ACT && !cur_wr)) |-> mem_we_n);
endmodule

// File: tb/sim_ext_mem_seq.sv
module sim_ext_mem_seq;
  import seq_pkg::*;
  localparam int NUM_CS = 4, NUM_WAIT = 2, AW = 16, DW = 16;
  localparam int CSW = 2, CFG_W = $bits(seq_cfg_t);

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_wr = 1'b0;
  logic [CSW-1:0] cfg_cs = '0;
  logic [CFG_W-1:0] cfg_data = '0;
  logic req_valid = 1'b0, req_wr = 1'b0;
  logic [CSW-1:0] req_cs = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_done, mem_adv_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [DW-1:0] rsp_rdata, mem_dout;
  logic [DW-1:0] mem_din = '0;
  logic [NUM_CS-1:0] mem_cs_n;
  logic [AW-1:0] mem_addr;
  logic [NUM_WAIT-1:0] mem_wait = '0;

  ext_mem_seq #(.NUM_CS(NUM_CS), .NUM_WAIT(NUM_WAIT), .ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_cs(cfg_cs), .cfg_data(cfg_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_wr(req_wr), .req_cs(req_cs),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .mem_cs_n(mem_cs_n), .mem_adv_n(mem_adv_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_dq_oe(mem_dq_oe),
    .mem_din(mem_din), .mem_wait(mem_wait));

  always #4 clk = ~clk;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  // active-high capture per sample index: p* after rising edge, n* after falling edge
  bit [63:0] pc, nc, pother, pa, po, pw, nw, pd;
  logic [DW-1:0] got_rdata, got_dout;
  logic [AW-1:0] got_addr;

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  function automatic int first1(input bit [63:0] v);
    for (int i = 0; i < 64; i++) if (v[i]) return i;
    return -1;
  endfunction

  function automatic int last1(input bit [63:0] v);
    for (int i = 63; i >= 0; i--) if (v[i]) return i;
    return -1;
  endfunction

  task automatic load_cfg(input int cs, input seq_cfg_t c);
    @(posedge clk); #1;
    cfg_wr = 1'b1; cfg_cs = CSW'(cs); cfg_data = c;
    @(posedge clk); #1;
    cfg_wr = 1'b0;
  endtask

  // one access; wait_until > 0 holds mem_wait[1] high until after sample wait_until-1
  task automatic run(input bit wr, input int cs, input logic [AW-1:0] a,
                     input logic [DW-1:0] wd, input int wait_until,
                     output int nwait, output int done_k);
    pc = '0; nc = '0; pother = '0; pa = '0; po = '0; pw = '0; nw = '0; pd = '0;
    req_wr = wr; req_cs = CSW'(cs); req_addr = a; req_wdata = wd; req_valid = 1'b1;
    mem_wait[1] = (wait_until > 0);
    nwait = 0;
    while (1) begin
      @(negedge clk);
      if (req_ready) break;
      nwait++;
    end
    @(posedge clk); #1;
    req_valid = 1'b0;
    mem_din = 16'h1000;
    done_k = -1;
    for (int k = 1; k < 60; k++) begin
      @(posedge clk); #1;
      pc[k] = ~mem_cs_n[cs];
      pother[k] = |(~mem_cs_n & ~(NUM_CS'(1) << cs));
      pa[k] = ~mem_adv_n; po[k] = ~mem_oe_n; pw[k] = ~mem_we_n; pd[k] = mem_dq_oe;
      if (k == 1) begin got_addr = mem_addr; got_dout = mem_dout; end
      if (rsp_done && done_k < 0) begin done_k = k; got_rdata = rsp_rdata; end
      mem_din = 16'h1000 + 16'(k);
      mem_wait[1] = (k < wait_until);
      @(negedge clk); #1;
      nc[k] = ~mem_cs_n[cs]; nw[k] = ~mem_we_n;
      if (done_k >= 0 && k >= done_k + 2) break;
    end
    mem_wait[1] = 1'b0;
  endtask

  seq_cfg_t cb;  // basic line-1 setup

  task automatic t_reset();
    @(negedge clk);
    chk("R1 cs_n idle", int'(mem_cs_n), 15);
    chk("R1 adv/oe/we idle", int'({mem_adv_n, mem_oe_n, mem_we_n}), 7);
    chk("R1 done low", int'(rsp_done), 0);
    chk("R1 dq_oe low", int'(mem_dq_oe), 0);
    chk("R1 ready high", int'(req_ready), 1);
  endtask

  task automatic t_zero();
    int nw_, dk;
    run(1'b0, 0, 16'h0001, 16'h0, 0, nw_, dk);
    chk("R11 zero cfg done tick", dk, 1);
    chk("R11 zero cfg no cs", first1(pc), -1);
    chk("R11 zero cfg no oe", first1(po), -1);
  endtask

  task automatic t_read_basic();
    int nw_, dk;
    cb = '0;
    cb.dev16 = 1; cb.cs_on = 1; cb.cs_rd_off = 6; cb.cs_wr_off = 3;
    cb.adv_on = 0; cb.adv_rd_off = 2; cb.adv_wr_off = 1;
    cb.oe_on = 2; cb.oe_off = 6; cb.we_on = 1; cb.we_off = 4;
    cb.rd_cyc = 7; cb.wr_cyc = 5; cb.acc = 5;
    load_cfg(1, cb);
    run(1'b0, 1, 16'h1234, 16'h0, 0, nw_, dk);
    chk("R2 read cs first", first1(pc), 2);
    chk("R2 read cs last", last1(pc), 6);
    chk("R2 other lines high", first1(pother), -1);
    chk("R3 read adv first", first1(pa), 1);
    chk("R3 read adv last", last1(pa), 2);
    chk("R4 read oe first", first1(po), 3);
    chk("R4 read oe last", last1(po), 6);
    chk("R4 no we on read", first1(pw), -1);
    chk("R5 read done tick", dk, 7);
    chk("R5 read data at acc", int'(got_rdata), 16'h1005);
    chk("R12 no dq_oe on read", first1(pd), -1);
    chk("R12 address", int'(got_addr), 16'h1234);
  endtask

  task automatic t_write_basic();
    int nw_, dk;
    run(1'b1, 1, 16'h0ABC, 16'h5A5A, 0, nw_, dk);
    chk("R2 write cs first", first1(pc), 2);
    chk("R2 write cs last", last1(pc), 3);
    chk("R3 write adv last", last1(pa), 1);
    chk("R4 write we first", first1(pw), 2);
    chk("R4 write we last", last1(pw), 4);
    chk("R4 no oe on write", first1(po), -1);
    chk("R5 write done tick", dk, 5);
    chk("R12 dq_oe first", first1(pd), 1);
    chk("R12 dq_oe last", last1(pd), 5);
    chk("R12 write data", int'(got_dout), 16'h5A5A);
  endtask

  task automatic t_aad();
    int nw_, dk;
    seq_cfg_t c;
    c = cb;
    c.mux = MUX_AAD; c.aad_adv_on = 1; c.aad_adv_rd_off = 3;
    c.aad_oe_on = 4; c.aad_oe_off = 6;
    load_cfg(2, c);
    run(1'b0, 2, 16'h0002, 16'h0, 0, nw_, dk);
    chk("R3 aad adv first", first1(pa), 2);
    chk("R3 aad adv last", last1(pa), 3);
    chk("R4 aad oe first", first1(po), 5);
    chk("R4 aad oe last", last1(po), 6);
  endtask

  task automatic t_half();
    int nw_, dk;
    seq_cfg_t c;
    c = '0;
    c.half_cs = 1; c.half_we = 1;
    c.cs_on = 1; c.cs_wr_off = 4; c.we_on = 2; c.we_off = 4; c.wr_cyc = 6;
    load_cfg(3, c);
    run(1'b1, 3, 16'h0003, 16'hABCD, 0, nw_, dk);
    chk("R7 cs low first at falling edge", first1(nc), 2);
    chk("R7 cs high again at falling edge", last1(nc), 4);
    chk("R7 cs first rising sample", first1(pc), 3);
    chk("R7 cs last rising sample", last1(pc), 5);
    chk("R7 we first falling sample", first1(nw), 3);
    chk("R7 we last rising sample", last1(pw), 5);
    chk("R9 narrow write data", int'(got_dout), 16'h00CD);
  endtask

  task automatic t_gran();
    int nw_, dk;
    seq_cfg_t c;
    c = '0;
    c.gran = 1; c.cs_on = 1; c.cs_rd_off = 3; c.rd_cyc = 4; c.acc = 2;
    load_cfg(3, c);
    run(1'b0, 3, 16'h0004, 16'h0, 0, nw_, dk);
    chk("R8 doubled cs first", first1(pc), 3);
    chk("R8 doubled cs last", last1(pc), 6);
    chk("R8 doubled done", dk, 8);
    chk("R9 narrow read data", int'(got_rdata), 16'h0004);
  endtask

  task automatic t_wait();
    int nw_, dk;
    seq_cfg_t c;
    c = '0;
    c.dev16 = 1; c.wait_rd = 1; c.wait_pin = 1;
    c.cs_on = 0; c.cs_rd_off = 8; c.cs_wr_off = 5; c.rd_cyc = 8; c.wr_cyc = 5; c.acc = 4;
    load_cfg(0, c);
    mem_wait[0] = 1'b1;  // unselected pin held in stall level
    run(1'b0, 0, 16'h0005, 16'h0, 7, nw_, dk);
    chk("R10 stalled done tick", dk, 11);
    chk("R10 data sampled after release", int'(got_rdata), 16'h1007);
    chk("R10 cs held during stall", last1(pc), 11);
    run(1'b1, 0, 16'h0006, 16'h1111, 20, nw_, dk);
    chk("R10 write monitoring off", dk, 5);
    mem_wait[0] = 1'b0;
  endtask

  task automatic t_gap();
    int nw_, dk;
    seq_cfg_t c;
    c = '0;
    c.dev16 = 1; c.ta = 4; c.c2c = 3; c.c2c_same = 1; c.c2c_diff = 0; c.rd_cyc = 2;
    load_cfg(0, c);
    run(1'b0, 0, 16'h0007, 16'h0, 0, nw_, dk);
    // previous run returned two idle cycles after done: expected wait = need - 3
    run(1'b0, 0, 16'h0008, 16'h0, 0, nw_, dk);
    chk("R6 same line gap", nw_, 7 - 3);
    run(1'b0, 1, 16'h0009, 16'h0, 0, nw_, dk);
    chk("R6 other line gap", nw_, 4 - 3);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_zero();
    t_read_basic();
    t_write_basic();
    t_aad();
    t_half();
    t_gran();
    t_wait();
    t_gap();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      finished = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule